// File: doc/BRIEF.md
# UART Line Status Generator

This block assembles the eight-bit line status word of a UART whose receive and transmit paths are buffered by FIFOs. It watches the receiver's per-character completion pulse together with that character's parity, framing and break tags. It decides whether the character may enter the receive FIFO, and it keeps its own shadow FIFO of those tags. As a result, the per-character error bits always describe the character at the head of the receive queue. It also keeps a count of tagged entries, which drives the FIFO-wide error summary bit.

The data FIFO lives outside the block and is written when `rx_push` is high. The CPU side pulses `rx_pop` when it takes a character from the head, and pulses `lsr_rd` when it reads the status word; that read clears the sticky error bits. The transmit side supplies the empty states of its FIFO and shift register. From these the block produces the holding-empty and transmitter-empty bits, plus an interrupt request gated by an enable input.

Status bit positions (bit 0 first): data ready, overrun, parity error, framing error, break, transmit FIFO empty, transmitter fully empty, receive FIFO error summary.

Top module: `uart_line_status`

## Requirements
- R1: Bit 0 is 1 exactly when the receive queue holds at least one entry. An accepted character adds an entry. `rx_pop` while the queue is non-empty removes the head, and `rx_pop` on an empty queue does nothing.
- R2: A character that completes while the queue already holds DEPTH entries is not pushed, even if `rx_pop` is high in the same cycle. Bit 1 is then 1 in the next cycle, and the queued tags are unchanged.
- R3: Bit 2 (parity, tag input `rx_par_err`) and bit 3 (framing, tag input `rx_frm_err`) become 1 one cycle after a character carrying that tag becomes the queue head. A character becomes the head either by entering an empty queue or by a pop that exposes it.
- R4: Bit 4 (break, tag input `rx_brk`) is set the same way from the break tag. Only the first completion with `rx_brk`=1 in a run is accepted. Later completions with `rx_brk`=1 are ignored (no push, no flag) until a completion with `rx_brk`=0 arrives.
- R5: Bits 1 to 4 are sticky. They clear in the cycle after an `lsr_rd` pulse, unless a set event for that bit occurs in the same cycle as the read, in which case the bit stays 1.
- R6: Bit 5 equals the value `tx_fifo_empty` had in the previous cycle: it is set once the transmit FIFO is empty and clears once a byte has been written to it.
- R7: Bit 6 equals the previous cycle's `tx_fifo_empty` AND `tx_shift_empty`.
- R8: Bit 7 is 1 exactly while at least one queued entry carries a parity, framing or break tag.
- R9: `thre_irq` equals bit 5 AND `thre_ie`, and it follows `thre_ie` within the same cycle.
- R10: `rx_push` is high in the cycle of a completion that is accepted, and only then.
- R11: After synchronous reset the queue is empty and the status word is 8'h60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | Receiver completed one character this cycle |
| rx_par_err | input | 1 | Parity tag of the completing character |
| rx_frm_err | input | 1 | Framing tag of the completing character |
| rx_brk | input | 1 | Completing frame is a break |
| rx_pop | input | 1 | CPU takes the head character of the receive queue |
| lsr_rd | input | 1 | CPU reads the status word (clears sticky bits) |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_empty | input | 1 | Transmit shift register holds no data |
| thre_ie | input | 1 | Enable for the holding-empty interrupt |
| rx_push | output | 1 | Write enable for the external receive data FIFO |
| lsr | output | 8 | Line status word |
| thre_irq | output | 1 | Holding-empty interrupt request |

## Verification
On every cycle the assertions check the following:
- A full queue never accepts a push, and a repeated break frame is never pushed.
- An overrun raises bit 1 in the next cycle.
- Sticky bits do not drop without a read.
- The transmit bits follow their inputs with one cycle of delay.
- The summary, transmitter-empty and interrupt bits stay consistent with the data-ready and holding-empty bits.

Only the bench's scenarios can show that the parity, framing and break bits refer to the character that is actually at the head. The same is true for the tagged-entry count dropping to zero exactly when the last tagged entry leaves. The bench checks both against a queue model over long sequences at low, medium and high fill levels, including a read that coincides with a set event.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_tag_t;

  localparam int TAG_W = $bits(rx_tag_t);
endpackage

// File: rtl/lsr_tag_fifo.sv
module lsr_tag_fifo
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  rx_tag_t       in_tag,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] err_cnt,
  output rx_tag_t       head_ev
);
  rx_tag_t         mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr, rd_nxt;
  logic            err_in, err_out;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // tag storage: no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_tag;
  end

  assign rd_nxt  = ptr_inc(rd_ptr);
  assign err_in  = push & (|in_tag);
  assign err_out = pop & (|mem[rd_ptr]);

  // tags of the character that becomes head at the next edge
  always_comb begin
    head_ev = '0;
    if (pop && occ >= CW'(2))
      head_ev = mem[rd_nxt];
    else if (push && (occ == '0 || (pop && occ == CW'(1))))
      head_ev = in_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      err_cnt <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= rd_nxt;
      occ     <= occ + CW'(push) - CW'(pop);
      err_cnt <= err_cnt + CW'(err_in) - CW'(err_out);
    end
  end
endmodule

// File: rtl/lsr_sticky.sv
module lsr_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= set[i] | (q[i] & ~clr);
    end
  end
endmodule

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic fifo_empty,
  input  logic shift_empty,
  output logic hold_empty,
  output logic all_empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_empty <= 1'b1;
      all_empty  <= 1'b1;
    end else begin
      hold_empty <= fifo_empty;
      all_empty  <= fifo_empty & shift_empty;
    end
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_done,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  input  logic       rx_brk,
  input  logic       rx_pop,
  input  logic       lsr_rd,
  input  logic       tx_fifo_empty,
  input  logic       tx_shift_empty,
  input  logic       thre_ie,
  output logic       rx_push,
  output logic [7:0] lsr,
  output logic       thre_irq
);
  logic          brk_held;
  logic          rx_char, q_full, ovr_ev, do_pop;
  logic [CW-1:0] occ, err_cnt;
  rx_tag_t       in_tag, head_ev;
  logic [3:0]    sticky_q;
  logic          hold_empty, all_empty;

  // break run tracking: only the first break frame of a run counts (R4)
  always_ff @(posedge clk) begin
    if (rst)          brk_held <= 1'b0;
    else if (rx_done) brk_held <= rx_brk;
  end

  assign rx_char = rx_done & ~(rx_brk & brk_held);
  assign q_full  = (occ == CW'(DEPTH));
  assign rx_push = rx_char & ~q_full;           // R10
  assign ovr_ev  = rx_char & q_full;            // R2
  assign do_pop  = rx_pop & (occ != '0);        // R1
  assign in_tag  = '{brk: rx_brk, fe: rx_frm_err, pe: rx_par_err};

  lsr_tag_fifo #(.DEPTH(DEPTH)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .push    (rx_push),
    .pop     (do_pop),
    .in_tag  (in_tag),
    .occ     (occ),
    .err_cnt (err_cnt),
    .head_ev (head_ev)
  );

  lsr_sticky #(.N(4)) u_sticky (
    .clk (clk),
    .rst (rst),
    .set ({head_ev.brk, head_ev.fe, head_ev.pe, ovr_ev}),
    .clr (lsr_rd),
    .q   (sticky_q)
  );

  lsr_tx_flags u_tx (
    .clk         (clk),
    .rst         (rst),
    .fifo_empty  (tx_fifo_empty),
    .shift_empty (tx_shift_empty),
    .hold_empty  (hold_empty),
    .all_empty   (all_empty)
  );

  assign lsr      = {(err_cnt != '0), all_empty, hold_empty, sticky_q, (occ != '0)};
  assign thre_irq = hold_empty & thre_ie;       // R9
endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_done,
  input logic          rx_brk,
  input logic          rx_pop,
  input logic          lsr_rd,
  input logic          tx_fifo_empty,
  input logic          rx_push,
  input logic [7:0]    lsr,
  input logic          thre_irq,
  input logic [CW-1:0] occ,
  input logic          brk_held
);
  a_r1_push_sets_ready: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !rx_pop) |=> lsr[0]);

  a_r2_full_no_push: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH)) |-> !rx_push);

  a_r2_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !(rx_brk && brk_held) && occ == CW'(DEPTH)) |=> lsr[1]);

  a_r4_single_break: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_brk && brk_held) |-> !rx_push);

  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !lsr_rd |=> (($past(lsr[4:1]) & ~lsr[4:1]) == 4'b0000));

  a_r6_thre_set: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_empty |=> lsr[5]);

  a_r6_thre_clr: assert property (@(posedge clk) disable iff (rst)
    !tx_fifo_empty |=> !lsr[5]);

  a_r7_temt_in_thre: assert property (@(posedge clk) disable iff (rst)
    lsr[6] |-> lsr[5]);

  a_r8_err_needs_data: assert property (@(posedge clk) disable iff (rst)
    lsr[7] |-> lsr[0]);

  a_r9_irq_needs_thre: assert property (@(posedge clk) disable iff (rst)
    thre_irq |-> lsr[5]);
endmodule

bind uart_line_status uart_line_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rx_done       (rx_done),
  .rx_brk        (rx_brk),
  .rx_pop        (rx_pop),
  .lsr_rd        (lsr_rd),
  .tx_fifo_empty (tx_fifo_empty),
  .rx_push       (rx_push),
  .lsr           (lsr),
  .thre_irq      (thre_irq),
  .occ           (occ),
  .brk_held      (brk_held)
);

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_done = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
  logic rx_pop = 0, lsr_rd = 0, thre_ie = 0;
  logic tx_fifo_empty = 1, tx_shift_empty = 1;
  logic rx_push, thre_irq;
  logic [7:0] lsr;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_line_status #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_pop(rx_pop),
    .lsr_rd(lsr_rd), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .thre_ie(thre_ie),
    .rx_push(rx_push), .lsr(lsr), .thre_irq(thre_irq)
  );

  // reference model: tag bits {brk, fe, pe}
  logic [2:0] mq[$];
  logic m_held = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bk = 0;
  logic m_thre = 1, m_temt = 1;
  logic m_push;
  logic [31:0] rs = 32'h1234_5679;

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    logic [2:0] tg, ev;
    logic ch, full, pp, ov;
    int n, errs;
    #1;
    tg   = {rx_brk, rx_frm_err, rx_par_err};
    n    = mq.size();
    full = (n == DEPTH);
    ch   = rx_done && !(rx_brk && m_held);
    m_push = ch && !full;
    ov   = ch && full;
    pp   = rx_pop && n != 0;
    chk(rx_push == m_push, "R10 push", rx_push, m_push);
    chk(thre_irq == (m_thre & thre_ie), "R9 irq", thre_irq, m_thre & thre_ie);
    ev = 3'b000;
    if (pp && n >= 2) ev = mq[1];
    else if (m_push && (n == 0 || (pp && n == 1))) ev = tg;
    @(posedge clk);
    #1;
    m_oe = ov    | (m_oe & ~lsr_rd);
    m_pe = ev[0] | (m_pe & ~lsr_rd);
    m_fe = ev[1] | (m_fe & ~lsr_rd);
    m_bk = ev[2] | (m_bk & ~lsr_rd);
    if (pp) void'(mq.pop_front());
    if (m_push) mq.push_back(tg);
    if (rx_done) m_held = rx_brk;
    m_thre = tx_fifo_empty;
    m_temt = tx_fifo_empty & tx_shift_empty;
    errs = 0;
    foreach (mq[i]) if (mq[i] != 3'b000) errs++;
    chk(lsr[0] == (mq.size() != 0), "R1 ready", lsr[0], mq.size() != 0);
    chk(lsr[1] == m_oe, "R2 overrun", lsr[1], m_oe);
    chk(lsr[3:2] == {m_fe, m_pe}, "R3 pe/fe", lsr[3:2], {m_fe, m_pe});
    chk(lsr[4] == m_bk, "R4 break", lsr[4], m_bk);
    chk(lsr[5] == m_thre, "R6 thre", lsr[5], m_thre);
    chk(lsr[6] == m_temt, "R7 temt", lsr[6], m_temt);
    chk(lsr[7] == (errs != 0), "R8 summary", lsr[7], errs != 0);
  endtask

  // randomized phase; thresholds out of 256
  task automatic run(input int ncyc, input int pop_t, input int brk_t, input int rd_t);
    for (int c = 0; c < ncyc; c++) begin
      logic [31:0] a, b;
      @(negedge clk);
      rs = rnd(rs); a = rs;
      rs = rnd(rs); b = rs;
      rx_done        = a[7:0] < 8'd110;
      rx_pop         = int'(a[15:8]) < pop_t;
      lsr_rd         = int'(a[23:16]) < rd_t;
      rx_brk         = int'(a[31:24]) < brk_t;
      rx_par_err     = b[2:0] == 3'd0;
      rx_frm_err     = b[5:3] == 3'd0;
      tx_fifo_empty  = b[8];
      tx_shift_empty = b[9] | b[10];
      thre_ie        = b[11];
      cycle();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(lsr == 8'h60, "R11 reset", lsr, 8'h60);   // R11
    chk(rx_push == 1'b0, "R11 reset push", rx_push, 0);

    // R6 R7 R9: exhaustive sweep of transmit inputs and enable
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {thre_ie, tx_shift_empty, tx_fifo_empty} = 3'(i);
      rx_done = 0; rx_pop = 0; lsr_rd = 0;
      cycle();
    end

    // R2 R5: fill queue, overrun coincident with pop, then read
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk);
      rx_done = 1; rx_brk = 0; rx_par_err = (i == 1); rx_frm_err = 0;
      rx_pop = (i == DEPTH); lsr_rd = 0;
      cycle();
    end
    @(negedge clk);
    rx_done = 0; rx_pop = 0; lsr_rd = 1;
    cycle();
    chk(lsr[1] == 1'b0, "R5 read clears overrun", lsr[1], 0);

    // R4: break run of three frames pushes once
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_done = 1; rx_brk = (i < 3); rx_pop = 1; lsr_rd = 0;
      cycle();
    end

    // R5: read coinciding with a set event keeps the bit
    @(negedge clk);
    rx_done = 0; rx_pop = 1; lsr_rd = 0;
    cycle();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rx_done = 1; rx_par_err = 1; rx_frm_err = 0; rx_brk = 0;
      rx_pop = (k == 0); lsr_rd = 1;
      cycle();
    end

    run(6000, 128, 30, 64);   // balanced
    run(3000, 30, 20, 40);    // mostly full: overrun
    run(3000, 230, 120, 90);  // mostly empty, break-heavy
    run(2000, 128, 0, 0);     // no reads: sticky build-up

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule